// File: doc/BRIEF.md
# Configurable SPI Master/Slave Port

This block is a byte-wide serial peripheral port that runs either as the clock-driving master or as a slave clocked from the pins. A three-bit mode code in the control register picks the role. Five codes make it a master with a fixed power-of-two divider of the system clock. One code makes it a master that toggles SCK once per pulse of an external timer tick. The last two make it a slave, one of which obeys the active-low select pin while the other ignores it. Software loads an outgoing byte and sets the start/busy bit. Eight bits are exchanged MSB first, and the incoming byte lands in a receive buffer.

The edge-select bit sets the idle level of SCK and which edge drives data. The edge that leaves the idle level drives the next bit onto SDO. The edge that returns to idle samples SDI. Between bytes SDO rests at a level chosen by a control bit. A slave that completes a byte while the previous one is still unread raises a sticky overflow flag and discards the new byte. A one-cycle byte-complete pulse is provided for interrupt logic. The slave samples its pins through two-stage synchronisers, so the system clock must run at least four times faster than the slave SCK.

Top module: `spi_port`

## Requirements
- R1: Address 0 is the control register, with bit0 enable, bit1 edge select, bit2 start/busy, bit3 SDO idle-low, bit4 overflow and bits 7:5 mode code. A read at address 1 returns the receive buffer, and a write at address 1 loads the transmit byte. After reset both read 0, both output enables are 0 and SDO is 1.
- R2: While enable is 0, sck_oe and sdo_oe are 0, a write of 1 to the busy bit leaves it 0, and SCK does not toggle.
- R3: In a slave mode (codes 110, 111), finishing a byte while the receive buffer is still unread sets bit4 and keeps the old buffer contents. Bit4 then stays set until a control write carries 0 in bit4; a write of 1 leaves it set.
- R4: In the master modes (codes 000-101) bit4 never sets, and every finished byte overwrites the receive buffer.
- R5: SCK idles at the edge-select value. The edge leaving idle drives the next bit on SDO, the edge returning to idle samples SDI, and bits go MSB first.
- R6: Writing 1 to the busy bit while enabled makes it read 1. It clears when the eighth bit is sampled, and byte_done pulses high for exactly one cycle just after that.
- R7: Outside a byte, SDO is 1 when bit3 is 0 and 0 when bit3 is 1.
- R8: Mode codes 000 to 100 give an SCK half period of 1, 2, 4, 8 and 16 system clocks.
- R9: Mode code 101 toggles SCK once per tmr_tick pulse and never without one, so 16 ticks make one byte.
- R10: With mode 110 and ss_n high, sdo_oe is 0 and SCK edges are ignored without losing the partial state.
- R11: With mode 111, ss_n has no effect: sdo_oe is 1 and bytes transfer.
- R12: Reading address 1 marks the buffer free, so the next slave byte loads it without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (frees receive buffer at address 1) |
| reg_addr | input | 1 | Register select: 0 control, 1 data |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data (combinational from reg_addr) |
| sck_in | input | 1 | SCK from the pin, used in slave modes |
| sck_out | output | 1 | SCK driven in master modes |
| sck_oe | output | 1 | SCK output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | SDO output enable |
| ss_n | input | 1 | Active-low slave select |
| tmr_tick | input | 1 | Timer pulse used as master clock source in mode 101 |
| byte_done | output | 1 | One-cycle pulse after each finished byte |

## Verification
In master mode the first SCK edge comes one clock after the start write. SDO changes on the same clock edge as the SCK edge that drives it, and byte_done rises one clock after the final SCK edge. In slave mode every response lags the pin by up to three clocks of synchronisation and edge detection. The bench samples at falling clock edges and holds each slave SCK level for eight clocks, so each result is read after its due cycle and before the next stimulus. Half periods, tick counts and byte_done pulses are counted cycle by cycle as they appear at the ports.

// File: rtl/spi_port_pkg.sv
// Shared definitions for the SPI port: control register field positions
// and the mode code encoding. Assumes an 8-bit control register layout.
package spi_port_pkg;

    localparam int CTRL_EN   = 0;
    localparam int CTRL_CES  = 1;
    localparam int CTRL_BUSY = 2;
    localparam int CTRL_SDOC = 3;
    localparam int CTRL_OVF  = 4;
    localparam int RATE_LSB  = 5;
    localparam int RATE_W    = 3;

    typedef enum logic [RATE_W-1:0] {
        RATE_DIV2     = 3'd0,
        RATE_DIV4     = 3'd1,
        RATE_DIV8     = 3'd2,
        RATE_DIV16    = 3'd3,
        RATE_DIV32    = 3'd4,
        RATE_TIMER    = 3'd5,
        RATE_SLV_SEL  = 3'd6,
        RATE_SLV_FREE = 3'd7
    } rate_e;

    // True for the two slave mode codes.
    function automatic logic is_slave(input rate_e r);
        return (r == RATE_SLV_SEL) || (r == RATE_SLV_FREE);
    endfunction

endpackage

// File: rtl/spi_sync.sv
// Multi-stage synchroniser for a small bundle of asynchronous pins.
// Assumes each bit is independent (no bundled-data coherence needed).
module spi_sync #(
    parameter int              W       = 2,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] st;

    generate
        if (STAGES == 1) begin : g_single
            // Single flop capture of the pins.
            always_ff @(posedge clk) begin
                if (!rst_n) st <= RST_VAL;
                else        st <= din;
            end
        end else begin : g_chain
            // Shift chain: new sample enters at stage 0.
            always_ff @(posedge clk) begin
                if (!rst_n) st <= {STAGES{RST_VAL}};
                else        st <= {st[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = st[STAGES-1];

endmodule

// File: rtl/spi_sck_gen.sv
// Master SCK toggle generator. Emits a one-cycle toggle request either
// every 2^code system clocks (codes 0..4) or on each timer tick (code 5).
// Assumes PRE_W is wide enough to hold the largest divider minus one.
module spi_sck_gen
    import spi_port_pkg::*;
#(
    parameter int PRE_W = 5
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  rate_e rate,
    input  logic  tmr_tick,
    output logic  toggle
);

    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] term;

    // Terminal count of the divider for the current mode code.
    always_comb term = PRE_W'((32'd1 << rate) - 32'd1);

    // Toggle request from the divider or from the timer tick.
    always_comb begin
        if (!run)                   toggle = 1'b0;
        else if (rate == RATE_TIMER) toggle = tmr_tick;
        else                        toggle = (cnt == term);
    end

    // Divider counter, restarted on every toggle and while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt <= '0;
        else if (!run || toggle)           cnt <= '0;
        else if (rate != RATE_TIMER)       cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/spi_shift_eng.sv
// Byte shift engine shared by master and slave. A lead pulse drives the
// next MSB onto the output, a trail pulse samples the input and counts.
// Assumes lead and trail pulses alternate, starting with lead.
module spi_shift_eng #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          lead,
    input  logic          trail,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          sdi,
    output logic          sdo_bit,
    output logic          active,
    output logic          done,
    output logic [DW-1:0] rx_next
);

    localparam int CNT_W = $clog2(DW);

    logic [DW-1:0]    sh;
    logic [CNT_W-1:0] cnt;

    assign rx_next = {sh[DW-2:0], sdi};
    assign done    = trail && (cnt == CNT_W'(DW - 1));

    // Shift register: sample on trail, parallel load otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     sh <= '0;
        else if (trail) sh <= rx_next;
        else if (load)  sh <= load_data;
    end

    // Bit counter, cleared when the port is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (done)     cnt <= '0;
        else if (trail)    cnt <= cnt + 1'b1;
    end

    // Output bit register, updated on each leading edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    sdo_bit <= 1'b0;
        else if (lead) sdo_bit <= sh[DW-1];
    end

    // In-byte flag: set by the first lead, cleared at byte end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) active <= 1'b0;
        else if (done)     active <= 1'b0;
        else if (lead)     active <= 1'b1;
    end

endmodule

// File: rtl/spi_port.sv
// Top of the SPI port: control and data registers, master/slave edge
// selection, receive buffer with slave overflow, pin enables.
// Assumes DW >= 8 and, in slave mode, clk at least 4x the SCK rate.
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DW          = 8,
    parameter int PRE_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic          reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          sck_in,
    output logic          sck_out,
    output logic          sck_oe,
    input  logic          sdi,
    output logic          sdo,
    output logic          sdo_oe,
    input  logic          ss_n,
    input  logic          tmr_tick,
    output logic          byte_done
);

    localparam logic [1:0] SYNC_RST = 2'b01;  // {sck, ss_n}

    logic          en_q, ces_q, busy_q, sdoc_q, ovf_q;
    rate_e         rate_q;
    logic [DW-1:0] rx_buf_q;
    logic          rx_full_q;
    logic          sck_q, sck_d, byte_done_q;

    logic          ctrl_wr, data_wr, data_rd, en_nxt;
    logic          slave, run, toggle;
    logic          sck_s, ss_s, ss_ok, s_go, s_rise, s_fall;
    logic          lead, trail, done, active, sdo_bit, set_ovf;
    logic [DW-1:0] rx_next;
    logic [1:0]    sync_out;

    // Register strobes decoded from the simple access port.
    always_comb begin
        ctrl_wr = reg_wr && !reg_addr;
        data_wr = reg_wr &&  reg_addr;
        data_rd = reg_rd &&  reg_addr;
        en_nxt  = ctrl_wr ? reg_wdata[CTRL_EN] : en_q;
    end

    assign slave = is_slave(rate_q);
    assign run   = en_q && !slave && busy_q;

    spi_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sck_in, ss_n}),
        .dout (sync_out)
    );
    assign sck_s = sync_out[1];
    assign ss_s  = sync_out[0];

    spi_sck_gen #(.PRE_W(PRE_W)) u_sck_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .rate    (rate_q),
        .tmr_tick(tmr_tick),
        .toggle  (toggle)
    );

    // Slave edge detection and master edge classification.
    always_comb begin
        ss_ok  = (rate_q != RATE_SLV_SEL) || !ss_s;
        s_go   = en_q && slave && ss_ok;
        s_rise = sck_s && !sck_d;
        s_fall = !sck_s && sck_d;
        if (slave) begin
            lead  = s_go && (ces_q ? s_fall : s_rise);
            trail = s_go && (ces_q ? s_rise : s_fall);
        end else begin
            lead  = toggle && (sck_q == ces_q);
            trail = toggle && (sck_q != ces_q);
        end
    end

    spi_shift_eng #(.DW(DW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!en_q),
        .lead     (lead),
        .trail    (trail),
        .load     (data_wr && !active),
        .load_data(reg_wdata),
        .sdi      (sdi),
        .sdo_bit  (sdo_bit),
        .active   (active),
        .done     (done),
        .rx_next  (rx_next)
    );

    assign set_ovf = done && slave && rx_full_q && !data_rd;

    // Control register fields, busy handshake and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            ces_q  <= 1'b0;
            sdoc_q <= 1'b0;
            rate_q <= RATE_DIV2;
            ovf_q  <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                en_q   <= reg_wdata[CTRL_EN];
                ces_q  <= reg_wdata[CTRL_CES];
                sdoc_q <= reg_wdata[CTRL_SDOC];
                rate_q <= rate_e'(reg_wdata[RATE_LSB +: RATE_W]);
            end
            ovf_q <= set_ovf || (ctrl_wr ? (ovf_q && reg_wdata[CTRL_OVF]) : ovf_q);
            if (!en_nxt || done)                      busy_q <= 1'b0;
            else if (ctrl_wr && reg_wdata[CTRL_BUSY]) busy_q <= 1'b1;
        end
    end

    // Receive buffer: load at byte end unless overflow, freed by a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf_q  <= '0;
            rx_full_q <= 1'b0;
        end else if (done && !set_ovf) begin
            rx_buf_q  <= rx_next;
            rx_full_q <= 1'b1;
        end else if (data_rd) begin
            rx_full_q <= 1'b0;
        end
    end

    // Master SCK level: parked at idle unless a byte is running.
    always_ff @(posedge clk) begin
        if (!rst_n)      sck_q <= 1'b0;
        else if (!run)   sck_q <= ces_q;
        else if (toggle) sck_q <= !sck_q;
    end

    // Previous synchronised SCK for edge detection; byte-done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d       <= 1'b0;
            byte_done_q <= 1'b0;
        end else begin
            sck_d       <= sck_s;
            byte_done_q <= done;
        end
    end

    // Pin drivers and register read mux.
    always_comb begin
        sck_out   = sck_q;
        sck_oe    = en_q && !slave;
        sdo       = active ? sdo_bit : !sdoc_q;
        sdo_oe    = en_q && (!slave || ss_ok);
        byte_done = byte_done_q;
        if (reg_addr) reg_rdata = rx_buf_q;
        else          reg_rdata = DW'({rate_q, ovf_q, sdoc_q, busy_q, ces_q, en_q});
    end

endmodule

// File: rtl/spi_port_chk.sv
// Property checker for spi_port, attached with bind. Observes control
// state and pins; assumes the synchroniser depth of the default build.
module spi_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       ces,
    input logic       busy,
    input logic       ovf,
    input logic [2:0] rate,
    input logic       sck_out,
    input logic       sck_oe,
    input logic       sdo_oe,
    input logic       ss_n,
    input logic       byte_done,
    input logic       reg_wr,
    input logic       reg_addr,
    input logic       wr_ovf_bit
);

    logic master;
    assign master = !(rate[2] && rate[1]);

    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!sck_oe && !sdo_oe));

    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(reg_wr && !reg_addr && !wr_ovf_bit)) |=> ovf);

    assert_no_master_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf && master) |=> !ovf);

    assert_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && master && !busy && $past(!busy) && $stable(ces)) |-> (sck_out == ces));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);

    assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> !busy);

    assert_ss_tristate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rate == 3'd6 && ss_n && $past(ss_n) && $past(ss_n, 2)) |-> !sdo_oe);

endmodule

bind spi_port spi_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en_q),
    .ces       (ces_q),
    .busy      (busy_q),
    .ovf       (ovf_q),
    .rate      (rate_q),
    .sck_out   (sck_out),
    .sck_oe    (sck_oe),
    .sdo_oe    (sdo_oe),
    .ss_n      (ss_n),
    .byte_done (byte_done),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .wr_ovf_bit(reg_wdata[4])
);

// File: tb/spi_port_test.sv
`timescale 1ns/1ps
module spi_port_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr, reg_rd, reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       sck_in, sck_out, sck_oe, sdi, sdo, sdo_oe, ss_n, tmr_tick, byte_done;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spi_port uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .ss_n(ss_n), .tmr_tick(tmr_tick),
        .byte_done(byte_done)
    );

    task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; reg_addr = 1'b0;
    endtask

    // Master byte: bench acts as the slave on the pins.
    task automatic m_xfer(input logic [2:0] rate, input logic ces, input logic sdoc,
                          input logic [7:0] tx, input logic [7:0] stx, input bit do_read);
        logic [7:0] got = '0;
        logic [7:0] rx;
        logic prev;
        int edges = 0, ticks = 0, dones = 0, bitn = 0, cyc = 0, last = 0;
        int gmin = 1000, gmax = 0;
        wr(1'b0, {rate, 1'b0, sdoc, 1'b0, ces, 1'b1});
        wr(1'b1, tx);
        chk("R5 SCK idle level", sck_out, ces);
        chk("R7 SDO idle level before byte", sdo, !sdoc);
        wr(1'b0, {rate, 1'b0, sdoc, 1'b1, ces, 1'b1});
        chk("R6 busy reads 1 after start", reg_rdata[2], 1);
        if (rate == 3'd5) begin
            repeat (12) @(negedge clk);
            chk("R9 no toggle without tick", sck_out, ces);
        end
        prev = sck_out;
        while (dones == 0 && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (byte_done) dones++;
            if (sck_out != prev) begin
                edges++;
                if (edges > 1) begin
                    if (cyc - last < gmin) gmin = cyc - last;
                    if (cyc - last > gmax) gmax = cyc - last;
                end
                last = cyc;
                if (sck_out != ces) begin
                    got = {got[6:0], sdo};
                    if (bitn < 8) sdi = stx[7 - bitn];
                    bitn++;
                end
                prev = sck_out;
            end
            if (rate == 3'd5) begin
                tmr_tick = (cyc % 4 == 0) && (dones == 0);
                if (tmr_tick) ticks++;
            end
        end
        tmr_tick = 1'b0;
        chk("R5 MSB-first shifted-out byte", got, tx);
        chk("R6 one byte_done pulse", dones, 1);
        chk("R6 busy clear after byte", reg_rdata[2], 0);
        chk("R5 SCK back at idle", sck_out, ces);
        chk("R7 SDO idle level after byte", sdo, !sdoc);
        if (rate < 3'd5) begin
            chk("R8 min half period", gmin, 1 << rate);
            chk("R8 max half period", gmax, 1 << rate);
        end else begin
            chk("R9 edges per byte", edges, 16);
            chk("R9 ticks per byte", ticks, 16);
        end
        if (do_read) begin
            rd(1'b1, rx);
            chk("R5 sampled byte in buffer", rx, stx);
        end
    endtask

    // Slave byte: bench drives SCK with 8-clock half periods.
    task automatic s_xfer(input logic ces, input logic [7:0] mtx,
                          output logic [7:0] got, output int dones);
        got = '0;
        dones = 0;
        for (int b = 0; b < 8; b++) begin
            sck_in = !ces;
            sdi = mtx[7 - b];
            repeat (8) begin @(negedge clk); if (byte_done) dones++; end
            got = {got[6:0], sdo};
            sck_in = ces;
            repeat (8) begin @(negedge clk); if (byte_done) dones++; end
        end
        repeat (8) begin @(negedge clk); if (byte_done) dones++; end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 sck_oe after reset", sck_oe, 0);
        chk("R1 sdo_oe after reset", sdo_oe, 0);
        chk("R1 sdo after reset", sdo, 1);
        rd(1'b0, d); chk("R1 control after reset", d, 0);
        rd(1'b1, d); chk("R1 buffer after reset", d, 0);
    endtask

    task automatic t_disabled();
        logic [7:0] d;
        wr(1'b0, 8'h04);
        repeat (40) @(negedge clk);
        rd(1'b0, d);
        chk("R2 busy stays 0 while disabled", d, 0);
        chk("R2 no SCK while disabled", sck_out, 0);
        chk("R2 sck_oe while disabled", sck_oe, 0);
        chk("R2 sdo_oe while disabled", sdo_oe, 0);
    endtask

    task automatic t_master_no_ovf();
        logic [7:0] d;
        m_xfer(3'd0, 1'b0, 1'b0, 8'h0F, 8'h81, 1'b0);
        m_xfer(3'd0, 1'b0, 1'b0, 8'hF0, 8'h42, 1'b0);
        rd(1'b0, d); chk("R4 master sets no overflow", d[4], 0);
        rd(1'b1, d); chk("R4 master overwrites buffer", d, 8'h42);
    endtask

    task automatic t_slave_free();
        logic [7:0] got, d;
        int dn;
        wr(1'b0, 8'hE1);
        wr(1'b1, 8'h96);
        chk("R11 sdo_oe with ss_n high", sdo_oe, 1);
        s_xfer(1'b0, 8'h3D, got, dn);
        chk("R11 slave shifted-out byte", got, 8'h96);
        chk("R11 slave byte_done", dn, 1);
        chk("R7 slave SDO idle high", sdo, 1);
        rd(1'b1, d); chk("R11 slave received byte", d, 8'h3D);
    endtask

    task automatic t_slave_select();
        logic [7:0] got, d;
        int dn;
        ss_n = 1'b1;
        wr(1'b0, 8'hC1);
        wr(1'b1, 8'h4E);
        repeat (4) @(negedge clk);
        chk("R10 sdo_oe off when deselected", sdo_oe, 0);
        s_xfer(1'b0, 8'h99, got, dn);
        chk("R10 edges ignored when deselected", dn, 0);
        ss_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 sdo_oe on when selected", sdo_oe, 1);
        s_xfer(1'b0, 8'h71, got, dn);
        chk("R10 shift state kept while deselected", got, 8'h4E);
        rd(1'b1, d); chk("R10 received after select", d, 8'h71);
        ss_n = 1'b1;
    endtask

    task automatic t_slave_ces1();
        logic [7:0] got, d;
        int dn;
        wr(1'b0, 8'h00);
        sck_in = 1'b1;
        repeat (4) @(negedge clk);
        wr(1'b0, 8'hEB);
        wr(1'b1, 8'hB2);
        s_xfer(1'b1, 8'h6C, got, dn);
        chk("R5 slave falling-lead byte out", got, 8'hB2);
        chk("R7 slave SDO idle low", sdo, 0);
        rd(1'b1, d); chk("R5 slave rising-sample byte in", d, 8'h6C);
        wr(1'b0, 8'h00);
        sck_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_overflow();
        logic [7:0] got, d;
        int dn;
        wr(1'b0, 8'hE1);
        s_xfer(1'b0, 8'h11, got, dn);
        rd(1'b0, d); chk("R3 no overflow on first byte", d[4], 0);
        s_xfer(1'b0, 8'h22, got, dn);
        rd(1'b0, d); chk("R3 overflow set", d[4], 1);
        wr(1'b0, 8'hF1);
        rd(1'b0, d); chk("R3 writing 1 keeps overflow", d[4], 1);
        wr(1'b0, 8'hE1);
        rd(1'b0, d); chk("R3 writing 0 clears overflow", d[4], 0);
        rd(1'b1, d); chk("R3 buffer kept old byte", d, 8'h11);
        s_xfer(1'b0, 8'h33, got, dn);
        rd(1'b0, d); chk("R12 read freed buffer, no overflow", d[4], 0);
        rd(1'b1, d); chk("R12 new byte loaded", d, 8'h33);
    endtask

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
        sck_in = 1'b0; sdi = 1'b0; ss_n = 1'b1; tmr_tick = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        m_xfer(3'd0, 1'b0, 1'b0, 8'hA5, 8'h3C, 1'b1);
        m_xfer(3'd2, 1'b1, 1'b1, 8'h5A, 8'hC3, 1'b1);
        m_xfer(3'd4, 1'b0, 1'b1, 8'h81, 8'h7E, 1'b1);
        m_xfer(3'd1, 1'b1, 1'b0, 8'h6B, 8'h94, 1'b1);
        m_xfer(3'd5, 1'b0, 1'b0, 8'hD2, 8'h2D, 1'b1);
        t_master_no_ovf();
        t_slave_free();
        t_slave_select();
        t_slave_ces1();
        t_overflow();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule